// File: doc/BRIEF.md
# SPI Serial Memory Slave Front-End

This block sits between an SPI bus and a 32K x 8 byte-addressed memory. The slave accepts chip select, serial clock and serial data in from the bus master and returns a serial data out with a separate output enable, so a pad buffer outside the block can tri-state the pin. The block runs on a fast system clock. All SPI pins are brought into that clock domain by synchronizer chains, and every SPI edge becomes a one-cycle strobe. On the memory side the block drives a simple synchronous port with one read strobe and one write strobe.

After chip select falls, the first byte is decoded as a command. Read and write commands take a two-byte address, most significant bit first. Only the low 15 bits of that address are used. Data then streams at incrementing addresses for as long as chip select stays low. The block also holds a small status register. Its bit 1 is a write-enable latch that gates every write, and its upper six bits can be written. An unrecognised command silences the block until the next deselect.

The SPI clock must stay high and low for at least 6 system clocks in each half period (SPI mode 0, idle low).

Top module: `spi_mem_slave`

## Requirements
- R1: Serial-in is sampled on rising serial-clock edges, most significant bit first. The first full byte after chip select falls is always the command.
- R2: The output enable is low while chip select is high and during the command and address bytes. It is high only while read data or status data is shifted out, and serial-out changes only after falling serial-clock edges.
- R3: Command 0x06 sets the write-enable latch and command 0x04 clears it. A status read (0x05) returns {bits 7:2, latch, 0}, and bit 0 always reads 0.
- R4: Status write (0x01) loads bits 7:2 from its first data byte only if the latch is set. Otherwise the status register is unchanged.
- R5: Read (0x03) takes two address bytes and uses the low 15 bits, so the first address bit shifted in is ignored. It then returns the addressed byte most significant bit first.
- R6: Read keeps returning bytes from incrementing addresses, and the address wraps from 0x7FFF to 0x0000.
- R7: Write (0x02) with the latch set stores each complete data byte at incrementing addresses, with the same wrap. A partial last byte is never stored, and two stores are never on adjacent cycles.
- R8: Write or status write with the latch clear stores nothing.
- R9: The latch clears when chip select rises after a write whose address was fully received, or after a status write whose data byte was received. If chip select rises during the address phase, the latch stays set.
- R10: After an unrecognised command, all further bytes are ignored and the output enable stays low until chip select goes high.
- R11: Chip select rising at any point, even mid-byte, resets the bit counter and returns the block to command decode.
- R12: After reset the output enable and both memory strobes are low and the status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from master |
| spi_si | input | 1 | Serial data from master |
| spi_so | output | 1 | Serial data to master |
| spi_so_oe | output | 1 | Enable for the external serial-out buffer |
| mem_addr | output | 15 | Memory address |
| mem_re | output | 1 | Memory read strobe; data expected one clock later |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
A serial-out bit becomes valid about three system clocks after a falling serial-clock edge: two synchronizer stages, one edge register, then the output register. The bench samples it at the next rising edge, eight clocks after the fall. A memory read strobe follows a completed byte by one clock, and its data reaches the output shifter two clocks later, well before the next falling edge. The latch-clear and return to command decode land within four clocks of chip select rising. Each frame therefore ends with a 32-clock gap before any following check. Memory contents are compared through later read commands, and write strobes are counted at the memory port.

// File: rtl/spi_mem_pkg.sv
// Package: shared command codes and sequencer state type for the SPI memory slave.
// Assumes 8-bit command bytes.
package spi_mem_pkg;
    localparam logic [7:0] OPC_SET_WE  = 8'h06;
    localparam logic [7:0] OPC_CLR_WE  = 8'h04;
    localparam logic [7:0] OPC_RD_STAT = 8'h05;
    localparam logic [7:0] OPC_WR_STAT = 8'h01;
    localparam logic [7:0] OPC_READ    = 8'h03;
    localparam logic [7:0] OPC_WRITE   = 8'h02;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_RD,
        ST_WR,
        ST_RDSTAT,
        ST_WRSTAT,
        ST_IGN
    } cmd_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: brings chip select, serial clock and serial data into the system
// clock domain and turns serial-clock and deselect transitions into strobes.
// Assumes STAGES >= 2 and SPI half periods of several system clocks.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic sck_in,
    input  logic si_in,
    output logic sel,
    output logic sel_drop,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] cs_ch, sck_ch, si_ch;
    logic              cs_prev, sck_prev;

    // Purpose: shift each pin through its synchronizer chain and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_ch    <= '1;
            sck_ch   <= '0;
            si_ch    <= '0;
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_ch    <= {cs_ch[LAST-1:0], cs_n_in};
            sck_ch   <= {sck_ch[LAST-1:0], sck_in};
            si_ch    <= {si_ch[LAST-1:0], si_in};
            cs_prev  <= cs_ch[LAST];
            sck_prev <= sck_ch[LAST];
        end
    end

    // Purpose: derive levels and single-cycle edge strobes.
    always_comb begin
        sel      = ~cs_ch[LAST];
        sel_drop = cs_ch[LAST] & ~cs_prev;
        sck_rise = sck_ch[LAST] & ~sck_prev & ~cs_ch[LAST];
        sck_fall = ~sck_ch[LAST] & sck_prev & ~cs_ch[LAST];
        si_s     = si_ch[LAST];
    end
endmodule

// File: rtl/spi_rx_deser.sv
// Module: collects serial-in bits, MSB first, on rising serial-clock strobes
// and flags each full byte. Assumes sel low clears the bit position.
module spi_rx_deser #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 sck_rise,
    input  logic                 si,
    output logic [$clog2(W)-1:0] bit_idx,
    output logic                 byte_stb,
    output logic [W-1:0]         byte_val
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;

    // Purpose: shift in a bit per rising edge and pulse when a byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            sh       <= '0;
            byte_stb <= 1'b0;
        end else if (!sel) begin
            cnt      <= '0;
            byte_stb <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (sck_rise) begin
                sh  <= {sh[W-2:0], si};
                cnt <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
                if (cnt == LAST_BIT) byte_stb <= 1'b1;
            end
        end
    end

    // Purpose: expose the bit position and the assembled byte.
    always_comb begin
        bit_idx  = cnt;
        byte_val = sh;
    end
endmodule

// File: rtl/spi_tx_ser.sv
// Module: holds the next byte to send and shifts it out MSB first on falling
// serial-clock strobes while output is enabled by the sequencer.
// Assumes the pending byte is loaded before the first falling edge of a byte.
module spi_tx_ser #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 sck_fall,
    input  logic                 tx_en,
    input  logic [$clog2(W)-1:0] bit_idx,
    input  logic                 ld,
    input  logic [W-1:0]         ld_byte,
    output logic                 so,
    output logic                 so_oe
);
    logic [W-1:0] pend, sh;

    // Purpose: capture the pending byte and drive one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            sh    <= '0;
            so    <= 1'b0;
            so_oe <= 1'b0;
        end else begin
            if (ld) pend <= ld_byte;
            if (!sel) begin
                so    <= 1'b0;
                so_oe <= 1'b0;
            end else if (sck_fall && tx_en) begin
                so_oe <= 1'b1;
                if (bit_idx == '0) begin
                    so <= pend[W-1];
                    sh <= {pend[W-2:0], 1'b0};
                end else begin
                    so <= sh[W-1];
                    sh <= {sh[W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_cmd_fsm.sv
// Module: decodes the command byte, gathers the address, sequences memory
// reads and writes, and owns the status register with its write-enable latch.
// Assumes ADDR_W > W so the address spans at least two bytes.
module spi_cmd_fsm
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_drop,
    input  logic              byte_stb,
    input  logic [W-1:0]      rx_byte,
    input  logic [W-1:0]      mem_rdata,
    output cmd_state_e        st,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [W-1:0]      mem_wdata,
    output logic              tx_ld,
    output logic [W-1:0]      tx_byte,
    output logic              tx_en,
    output logic              wel
);
    localparam int ADDR_BYTES = (ADDR_W + W - 1) / W;
    localparam int AW8        = ADDR_BYTES * W;
    localparam int ACW        = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [ACW-1:0] LAST_AB = ACW'(ADDR_BYTES - 1);

    logic [AW8-1:0]    ash, a_next;
    logic [ADDR_W-1:0] a_full, cur;
    logic [ACW-1:0]    acnt;
    logic              is_rd, rd_pend, st_ld, wel_clr;
    logic [W-1:3]      stat_hi_u;
    logic              stat_b2;
    logic [W-1:0]      status;

    // Purpose: form the next address shift value and the status byte.
    always_comb begin
        a_next = {ash[AW8-W-1:0], rx_byte};
        a_full = a_next[ADDR_W-1:0];
        status = {stat_hi_u, stat_b2, wel, 1'b0};
        tx_ld  = rd_pend | st_ld;
        tx_byte = rd_pend ? mem_rdata : status;
        tx_en  = (st == ST_RD) || (st == ST_RDSTAT);
    end

    // Purpose: command sequencer, memory strobes and status register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_OPC;
            ash       <= '0;
            cur       <= '0;
            acnt      <= '0;
            is_rd     <= 1'b0;
            mem_addr  <= '0;
            mem_re    <= 1'b0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            rd_pend   <= 1'b0;
            st_ld     <= 1'b0;
            wel       <= 1'b0;
            wel_clr   <= 1'b0;
            stat_hi_u <= '0;
            stat_b2   <= 1'b0;
        end else begin
            mem_re  <= 1'b0;
            mem_we  <= 1'b0;
            rd_pend <= mem_re;
            st_ld   <= 1'b0;
            if (sel_drop) begin
                st      <= ST_OPC;
                acnt    <= '0;
                wel_clr <= 1'b0;
                if (wel_clr) wel <= 1'b0;
            end else if (byte_stb) begin
                case (st)
                    ST_OPC: begin
                        case (rx_byte)
                            OPC_SET_WE:  begin wel <= 1'b1; st <= ST_IGN; end
                            OPC_CLR_WE:  begin wel <= 1'b0; st <= ST_IGN; end
                            OPC_RD_STAT: begin st <= ST_RDSTAT; st_ld <= 1'b1; end
                            OPC_WR_STAT: st <= wel ? ST_WRSTAT : ST_IGN;
                            OPC_READ:    begin st <= ST_ADDR; is_rd <= 1'b1; end
                            OPC_WRITE:   begin
                                st    <= wel ? ST_ADDR : ST_IGN;
                                is_rd <= 1'b0;
                            end
                            default:     st <= ST_IGN;
                        endcase
                    end
                    ST_ADDR: begin
                        ash <= a_next;
                        if (acnt == LAST_AB) begin
                            acnt <= '0;
                            cur  <= a_full;
                            if (is_rd) begin
                                st       <= ST_RD;
                                mem_addr <= a_full;
                                mem_re   <= 1'b1;
                            end else begin
                                st      <= ST_WR;
                                wel_clr <= 1'b1;
                            end
                        end else begin
                            acnt <= acnt + 1'b1;
                        end
                    end
                    ST_RD: begin
                        cur      <= cur + 1'b1;
                        mem_addr <= cur + 1'b1;
                        mem_re   <= 1'b1;
                    end
                    ST_WR: begin
                        mem_we    <= 1'b1;
                        mem_addr  <= cur;
                        mem_wdata <= rx_byte;
                        cur       <= cur + 1'b1;
                    end
                    ST_RDSTAT: st_ld <= 1'b1;
                    ST_WRSTAT: begin
                        stat_hi_u <= rx_byte[W-1:3];
                        stat_b2   <= rx_byte[2];
                        wel_clr   <= 1'b1;
                        st        <= ST_IGN;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_mem_slave.sv
// Module: top of the SPI memory slave. Wires the pin synchronizer, byte
// receiver, byte sender and command sequencer. Assumes mode-0 SPI, a memory
// with one-cycle read latency, and an external buffer gated by spi_so_oe.
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    localparam int BCW = $clog2(BYTE_W);

    logic              sel, sel_drop, sck_rise, sck_fall, si_s;
    logic [BCW-1:0]    bit_idx;
    logic              byte_stb;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_ld, tx_en, wel_q;
    logic [BYTE_W-1:0] tx_byte;
    cmd_state_e        cmd_st;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n_in(spi_cs_n), .sck_in(spi_sck), .si_in(spi_si),
        .sel(sel), .sel_drop(sel_drop),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
    );

    spi_rx_deser #(.W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sck_rise(sck_rise), .si(si_s),
        .bit_idx(bit_idx), .byte_stb(byte_stb), .byte_val(rx_byte)
    );

    spi_tx_ser #(.W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sck_fall(sck_fall),
        .tx_en(tx_en), .bit_idx(bit_idx), .ld(tx_ld), .ld_byte(tx_byte),
        .so(spi_so), .so_oe(spi_so_oe)
    );

    spi_cmd_fsm #(.ADDR_W(ADDR_W), .W(BYTE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_drop(sel_drop),
        .byte_stb(byte_stb), .rx_byte(rx_byte), .mem_rdata(mem_rdata),
        .st(cmd_st), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .tx_ld(tx_ld), .tx_byte(tx_byte),
        .tx_en(tx_en), .wel(wel_q)
    );
endmodule

// File: rtl/spi_mem_slave_chk.sv
// Module: property checker for the SPI memory slave, attached by bind.
module spi_mem_slave_chk
    import spi_mem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sel_drop,
    input cmd_state_e st,
    input logic       so_oe,
    input logic       mem_we,
    input logic       mem_re,
    input logic       wel
);
    p_oe_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPC || st == ST_ADDR || st == ST_WR) |-> !so_oe);

    p_rw_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_we_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_we_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(wel));

    p_ign_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGN) |-> (!so_oe && !mem_re && !mem_we));

    p_drop_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_drop |=> (!so_oe && st == ST_OPC));
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel_drop(sel_drop), .st(cmd_st),
    .so_oe(spi_so_oe), .mem_we(mem_we), .mem_re(mem_re), .wel(wel_q)
);

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_si = 1'b0;
    logic        spi_so, spi_so_oe;
    logic [14:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    int checks = 0;
    int fails = 0;
    int we_cnt = 0;
    int we_exp = 0;

    logic [7:0] dmem [int];
    logic [7:0] rmem [int];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] wq [$];

    bit         mon_on = 1'b0;
    logic [7:0] cap = 8'h00;
    int         nb = 0;
    bit         oe_bad = 1'b0;

    bit         wel_m = 1'b0;
    logic [5:0] stat_m = 6'h00;

    always #2 clk = ~clk;

    spi_mem_slave dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model with one-cycle read latency and a write strobe counter
    always @(posedge clk) begin
        if (mem_we) begin
            dmem[int'(mem_addr)] = mem_wdata;
            we_cnt++;
        end
        if (mem_re) mem_rdata <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : 8'h00;
    end

    function automatic logic [7:0] ref_rd(int a);
        return rmem.exists(a) ? rmem[a] : 8'h00;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: assembles output bytes and pops the scoreboard
    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (mon_on) begin
                if (!spi_so_oe) oe_bad = 1'b1;
                cap = {cap[6:0], spi_so};
                nb++;
                if (nb == 8) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "scoreboard-empty", int'(cap), 0);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(cap == e && !oe_bad, t, int'(cap), int'(e));
                    end
                    nb = 0;
                    oe_bad = 1'b0;
                end
            end else if (spi_so_oe) begin
                chk(1'b0, "R2 oe during cmd/addr/ignored byte", 1, 0);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_on();
        spi_cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic sel_off();
        tick(HALF);
        spi_cs_n = 1'b1;
        tick(4 * HALF);
        chk(spi_so_oe == 1'b0, "R2 oe low after deselect", int'(spi_so_oe), 0);
    endtask

    task automatic send_bits(logic [7:0] v, int n);
        for (int i = 7; i > 7 - n; i--) begin
            spi_si = v[i];
            tick(HALF);
            spi_sck = 1'b1;
            tick(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic xbyte(logic [7:0] v, bit capture);
        mon_on = capture;
        nb = 0;
        send_bits(v, 8);
        mon_on = 1'b0;
    endtask

    task automatic cmd1(logic [7:0] op);
        sel_on();
        xbyte(op, 1'b0);
        sel_off();
    endtask

    task automatic rd_status(string tag);
        sel_on();
        xbyte(8'h05, 1'b0);
        for (int i = 0; i < 2; i++) begin
            exp_q.push_back({stat_m, wel_m, 1'b0});
            tag_q.push_back(tag);
            xbyte(8'h00, 1'b1);
        end
        sel_off();
    endtask

    task automatic wr_status(logic [7:0] v);
        sel_on();
        xbyte(8'h01, 1'b0);
        xbyte(v, 1'b0);
        sel_off();
        if (wel_m) begin
            stat_m = v[7:2];
            wel_m = 1'b0;
        end
    endtask

    task automatic rd_mem(logic [15:0] a, int n, string tag);
        sel_on();
        xbyte(8'h03, 1'b0);
        xbyte(a[15:8], 1'b0);
        xbyte(a[7:0], 1'b0);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(ref_rd((int'(a[14:0]) + i) % 32768));
            tag_q.push_back(tag);
            xbyte(8'h00, 1'b1);
        end
        sel_off();
    endtask

    // writes wq at address a; partial_bits > 0 appends an incomplete byte
    task automatic wr_mem(logic [15:0] a, int partial_bits);
        int k = 0;
        sel_on();
        xbyte(8'h02, 1'b0);
        xbyte(a[15:8], 1'b0);
        xbyte(a[7:0], 1'b0);
        foreach (wq[i]) begin
            xbyte(wq[i], 1'b0);
            if (wel_m) begin
                rmem[(int'(a[14:0]) + k) % 32768] = wq[i];
                we_exp++;
            end
            k++;
        end
        if (partial_bits > 0) send_bits(8'hFF, partial_bits);
        sel_off();
        wel_m = 1'b0;
        wq.delete();
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(4);
        // R12: reset state
        chk(spi_so_oe == 1'b0, "R12 oe after reset", int'(spi_so_oe), 0);
        chk(mem_we == 1'b0 && mem_re == 1'b0, "R12 strobes after reset", int'({mem_we, mem_re}), 0);
        rd_status("R12 R1 status after reset");

        // R3: latch set and clear
        cmd1(8'h06); wel_m = 1'b1;
        rd_status("R3 latch set by 0x06");
        cmd1(8'h04); wel_m = 1'b0;
        rd_status("R3 latch cleared by 0x04");

        // R4: status write gated by latch
        wr_status(8'hFC);
        rd_status("R4 status write without latch");
        cmd1(8'h06); wel_m = 1'b1;
        wr_status(8'hFF);
        rd_status("R4 R9 status write with latch");
        cmd1(8'h06); wel_m = 1'b1;
        wr_status(8'h00);
        rd_status("R4 status cleared");

        // R7 R5 R6: burst write then read back
        cmd1(8'h06); wel_m = 1'b1;
        wq = '{8'hA5, 8'h3C, 8'h0F};
        wr_mem(16'h1234, 0);
        rd_status("R9 latch cleared after write");
        chk(we_cnt == we_exp, "R7 write strobe count", we_cnt, we_exp);
        rd_mem(16'h1234, 3, "R5 R6 burst read");
        rd_mem(16'h9234, 2, "R5 top address bit ignored");

        // R6 R7: wrap at top of memory
        cmd1(8'h06); wel_m = 1'b1;
        wq = '{8'h11, 8'h22};
        wr_mem(16'h7FFF, 0);
        rd_mem(16'h7FFE, 3, "R6 R7 wrap 7FFF to 0000");

        // R7: partial trailing byte discarded
        cmd1(8'h06); wel_m = 1'b1;
        wq = '{8'h77};
        wr_mem(16'h0100, 4);
        chk(we_cnt == we_exp, "R7 partial byte not stored", we_cnt, we_exp);
        rd_mem(16'h0100, 2, "R7 partial byte discarded");

        // R8: write without latch
        wq = '{8'h99};
        wr_mem(16'h0100, 0);
        chk(we_cnt == we_exp, "R8 no store without latch", we_cnt, we_exp);
        rd_mem(16'h0100, 1, "R8 data unchanged");

        // R10: invalid command silences everything until deselect
        cmd1(8'h06); wel_m = 1'b1;
        sel_on();
        xbyte(8'hAB, 1'b0);
        xbyte(8'h04, 1'b0);
        xbyte(8'h02, 1'b0);
        xbyte(8'h00, 1'b0);
        xbyte(8'h10, 1'b0);
        xbyte(8'h55, 1'b0);
        sel_off();
        chk(we_cnt == we_exp, "R10 no store after invalid command", we_cnt, we_exp);
        rd_status("R10 latch untouched after invalid command");

        // R9: deselect during address phase keeps the latch
        sel_on();
        xbyte(8'h02, 1'b0);
        xbyte(8'h01, 1'b0);
        sel_off();
        rd_status("R9 latch kept on aborted address");
        cmd1(8'h04); wel_m = 1'b0;

        // R11: abort mid-byte then a clean command
        sel_on();
        send_bits(8'h05, 3);
        sel_off();
        rd_status("R11 bit counter reset by deselect");
        rd_mem(16'h1235, 2, "R11 R1 read after abort");

        chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule